// File: doc/BRIEF.md
# Processor Program Memory Loader

This block gives a host a narrow register window for filling and checking the byte-wide program memory of an embedded processor, and for holding that processor stopped or letting it run. The host first writes a halt word into the control register, which asserts the processor reset and opens the memory to the host. It then zeroes the pointer register and streams bytes through the data register. The pointer moves forward by one on every data access. To verify the load, the host zeroes the pointer again and reads the bytes back in the same order. It then writes a run word, which releases the processor reset and starts the processor clock.

The register bus carries a byte address, a write strobe, a read strobe, write data and registered read data. The control, pointer and data registers sit at offsets 0x10, 0x11 and 0x12. The processor side gets three levels from the control register: clock enable, boot enable and reset. The memory is an internal byte array whose depth is a parameter and must be a power of two. The asynchronous active-low reset input is released into the block through a two-stage synchronizer.

Top module: `mcode_loader`

## Requirements
- R1: Two clock edges after `rst_n` rises, the block is out of reset in the following state: control register 0, pointer 0, `bus_rdata` 0, `cpu_reset` 1, `cpu_clk_en` 0, `cpu_boot_en` 0.
- R2: A write to offset 0x10 stores bits 8:0 of `bus_wdata` in the control register, and higher bits are dropped. A read of 0x10 returns the stored 9 bits with all higher bits zero. The bit positions are: 8 clock divide, 7 reset hold, 3 boot enable, 2 external access enable, 1 clock enable, 0 run release.
- R3: The processor outputs follow the control register from the edge that stores it. `cpu_clk_en` follows bit 1 and `cpu_boot_en` follows bit 3. `cpu_reset` is 1 when bit 7 is set or bit 0 is clear. The halt word 0x08C gives reset 1, clock 0 and boot 1. The run word 0x10B gives reset 0, clock 1 and boot 1.
- R4: A write to offset 0x11 loads the pointer with the low log2(DEPTH) bits of `bus_wdata`, so writing 0 selects the first byte. A read of 0x11 returns the pointer, zero-extended.
- R5: While control bit 2 is set, a write to offset 0x12 stores `bus_wdata[7:0]` at the pointer and advances the pointer by one.
- R6: While control bit 2 is set, a read of offset 0x12 returns the byte at the pointer in bits 7:0 with all higher bits zero, and advances the pointer by one.
- R7: When a data access advances the pointer from DEPTH-1, the pointer wraps to 0.
- R8: While control bit 2 is clear, data writes leave the memory unchanged, data reads return 0, and neither moves the pointer.
- R9: Read data appears on `bus_rdata` one cycle after the read strobe and is held until the next accepted read. Reads of unmapped offsets return 0. Writes to unmapped offsets change nothing.
- R10: When both strobes are asserted in one cycle, only the write is performed, and `bus_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W (32) | Registered read data |
| cpu_clk_en | output | 1 | Processor clock enable |
| cpu_boot_en | output | 1 | Processor boot enable |
| cpu_reset | output | 1 | Processor reset, active high |

## Verification
Writes to the control, pointer and memory take effect on the clock edge that samples the strobe, so the processor outputs and the pointer carry the new value right after that edge. Read data lands on `bus_rdata` on the same edge and stays there until the next accepted read. The internal reset lifts two edges after `rst_n` rises. The bench drives every access on a falling edge and steps a behavioural model on the following rising edge. At the next falling edge it compares all outputs with the model, so each result is checked in the first half-cycle in which it is due.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
  localparam int BUS_AW = 8;
  localparam int CTL_W  = 9;

  localparam logic [BUS_AW-1:0] OFF_CTL = 8'h10;
  localparam logic [BUS_AW-1:0] OFF_PTR = 8'h11;
  localparam logic [BUS_AW-1:0] OFF_DAT = 8'h12;

  localparam int CB_CLKDIV = 8;
  localparam int CB_HOLD   = 7;
  localparam int CB_BOOT   = 3;
  localparam int CB_EXTACC = 2;
  localparam int CB_CLKEN  = 1;
  localparam int CB_RUN    = 0;

  localparam logic [CTL_W-1:0] WORD_HALT = 9'h08C;
  localparam logic [CTL_W-1:0] WORD_RUN  = 9'h10B;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_DAT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mcl_rst_sync.sv
module mcl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/mcl_ctrl_reg.sv
module mcl_ctrl_reg
  import mcl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_val,
  output logic [CTL_W-1:0] ctl_q,
  output logic             ext_acc,
  output logic             cpu_clk_en,
  output logic             cpu_boot_en,
  output logic             cpu_reset
);
  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ext_acc     = ctl_q[CB_EXTACC];
  assign cpu_clk_en  = ctl_q[CB_CLKEN];
  assign cpu_boot_en = ctl_q[CB_BOOT];
  assign cpu_reset   = ctl_q[CB_HOLD] | ~ctl_q[CB_RUN];

  AST_CTL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl_q == $past(wr_val)));  // R2

  AST_HALT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_val == WORD_HALT) |=> (cpu_reset && !cpu_clk_en && cpu_boot_en));  // R3

  AST_RUN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_val == WORD_RUN) |=> (!cpu_reset && cpu_clk_en && cpu_boot_en));  // R3
endmodule

// File: rtl/mcl_addr_ptr.sv
module mcl_addr_ptr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] ptr_q
);
  logic [AW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)     ptr_d = load_val;
    else if (adv) ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (ptr_q == $past(ptr_q) + AW'(1)));  // R7

  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(ptr_q));  // R8
endmodule

// File: rtl/mcl_byte_store.sv
module mcl_byte_store #(
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wr_byte,
  output logic [7:0]    rd_byte
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_byte;
  end

  assign rd_byte = mem[addr];
endmodule

// File: rtl/mcode_loader.sv
module mcode_loader
  import mcl_pkg::*;
#(
  parameter int DEPTH  = 4096,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_clk_en,
  output logic              cpu_boot_en,
  output logic              cpu_reset
);
  localparam int AW = $clog2(DEPTH);

  logic             srst_n;
  reg_sel_e         sel;
  logic             wr_fire, rd_fire;
  logic             ctl_wr, ptr_load, dat_adv, mem_wr;
  logic [CTL_W-1:0] ctl_q;
  logic             ext_acc;
  logic [AW-1:0]    ptr_q;
  logic [7:0]       rd_byte;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  mcl_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    unique case (bus_addr)
      OFF_CTL: sel = SEL_CTL;
      OFF_PTR: sel = SEL_PTR;
      OFF_DAT: sel = SEL_DAT;
      default: sel = SEL_NONE;
    endcase
  end

  assign wr_fire  = bus_wr;
  assign rd_fire  = bus_rd & ~bus_wr;
  assign ctl_wr   = wr_fire & (sel == SEL_CTL);
  assign ptr_load = wr_fire & (sel == SEL_PTR);
  assign mem_wr   = wr_fire & (sel == SEL_DAT) & ext_acc;
  assign dat_adv  = (sel == SEL_DAT) & ext_acc & (bus_wr | bus_rd);

  mcl_ctrl_reg u_ctl (
    .clk         (clk),
    .rst_n       (srst_n),
    .wr_en       (ctl_wr),
    .wr_val      (bus_wdata[CTL_W-1:0]),
    .ctl_q       (ctl_q),
    .ext_acc     (ext_acc),
    .cpu_clk_en  (cpu_clk_en),
    .cpu_boot_en (cpu_boot_en),
    .cpu_reset   (cpu_reset)
  );

  mcl_addr_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (ptr_load),
    .load_val (bus_wdata[AW-1:0]),
    .adv      (dat_adv),
    .ptr_q    (ptr_q)
  );

  mcl_byte_store #(.DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .wr_en   (mem_wr),
    .addr    (ptr_q),
    .wr_byte (bus_wdata[7:0]),
    .rd_byte (rd_byte)
  );

  always_comb begin
    rd_val = '0;
    unique case (sel)
      SEL_CTL: rd_val = DATA_W'(ctl_q);
      SEL_PTR: rd_val = DATA_W'(ptr_q);
      SEL_DAT: rd_val = ext_acc ? DATA_W'(rd_byte) : '0;
      default: rd_val = '0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_fire) rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  AST_BYTE_WIDE: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_fire && bus_addr == OFF_DAT) |=> (bus_rdata[DATA_W-1:8] == '0));  // R6

  AST_DATA_OFF: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_fire && bus_addr == OFF_DAT && !cpu_reset_gate_n()) |=> (bus_rdata == '0));  // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (!bus_rd || bus_wr) |=> $stable(bus_rdata));  // R10

  AST_UNMAPPED: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_fire && bus_addr != OFF_CTL && bus_addr != OFF_PTR && bus_addr != OFF_DAT)
      |=> (bus_rdata == '0));  // R9

  function automatic logic cpu_reset_gate_n();
    return ctl_q[CB_EXTACC];
  endfunction
endmodule

// File: tb/sim_mcode_loader.sv
module sim_mcode_loader;
  localparam int DEPTH = 4096;
  localparam int DW    = 32;
  localparam int MASK  = DEPTH - 1;

  logic          clk;
  logic          rst_n;
  logic [7:0]    bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_wr, bus_rd;
  logic [DW-1:0] bus_rdata;
  logic          cpu_clk_en, cpu_boot_en, cpu_reset;

  int n_chk = 0;
  int n_bad = 0;

  int          m_ctl;
  int          m_ptr;
  logic [31:0] m_rdata;
  logic [7:0]  m_mem [int];

  mcode_loader #(.DEPTH(DEPTH), .DATA_W(DW)) u0 (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
    .cpu_clk_en (cpu_clk_en), .cpu_boot_en (cpu_boot_en), .cpu_reset (cpu_reset)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic model_step(logic wr, logic rd, logic [7:0] a, logic [31:0] d);
    bit ext = m_ctl[2];
    if (wr) begin
      if (a == 8'h10) m_ctl = int'(d & 32'h1FF);
      else if (a == 8'h11) m_ptr = int'(d) & MASK;
      else if (a == 8'h12 && ext) begin
        m_mem[m_ptr] = d[7:0];
        m_ptr = (m_ptr + 1) & MASK;
      end
    end else if (rd) begin
      if (a == 8'h10) m_rdata = 32'(m_ctl);
      else if (a == 8'h11) m_rdata = 32'(m_ptr);
      else if (a == 8'h12 && ext) begin
        m_rdata = {24'h0, m_mem[m_ptr]};
        m_ptr = (m_ptr + 1) & MASK;
      end else m_rdata = 32'h0;
    end
  endtask

  task automatic compare(string tag);
    logic e_rst, e_clk, e_boot;
    e_clk  = m_ctl[1];
    e_boot = m_ctl[3];
    e_rst  = m_ctl[7] | ~m_ctl[0];
    n_chk++;
    if (bus_rdata !== m_rdata || cpu_clk_en !== e_clk ||
        cpu_boot_en !== e_boot || cpu_reset !== e_rst) begin
      n_bad++;
      $display("FAIL %s: actual rdata=%h clk=%b boot=%b rst=%b expected rdata=%h clk=%b boot=%b rst=%b",
               tag, bus_rdata, cpu_clk_en, cpu_boot_en, cpu_reset,
               m_rdata, e_clk, e_boot, e_rst);
    end
  endtask

  task automatic cyc(string tag, logic wr, logic rd, logic [7:0] a, logic [31:0] d);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_step(wr, rd, a, d);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    compare(tag);
  endtask

  task automatic wr(string tag, logic [7:0] a, logic [31:0] d);
    cyc(tag, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(string tag, logic [7:0] a);
    cyc(tag, 1'b0, 1'b1, a, 32'h0);
  endtask

  task automatic idle(string tag);
    cyc(tag, 1'b0, 1'b0, 8'h00, 32'h0);
  endtask

  initial begin
    m_ctl = 0; m_ptr = 0; m_rdata = '0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    idle("R1"); idle("R1");
    rd("R2", 8'h10);
    rd("R4", 8'h11);

    // R2 / R3 halt word with junk in upper bits
    wr("R3", 8'h10, 32'hABCD_E08C);
    rd("R2", 8'h10);

    // R4 / R5 load three bytes from location 0
    wr("R4", 8'h11, 32'h0);
    wr("R5", 8'h12, 32'h0000_01A5);
    wr("R5", 8'h12, 32'hFFFF_FF3C);
    wr("R5", 8'h12, 32'h0000_00FF);
    rd("R5", 8'h11);

    // R6 read back
    wr("R4", 8'h11, 32'h0);
    rd("R6", 8'h12);
    rd("R6", 8'h12);
    rd("R6", 8'h12);
    rd("R6", 8'h11);

    // R7 wrap at top of memory, R4 truncation of pointer write
    wr("R4", 8'h11, 32'h0000_1FFE);
    rd("R4", 8'h11);
    wr("R7", 8'h12, 32'h11);
    wr("R7", 8'h12, 32'h22);
    rd("R7", 8'h11);
    wr("R7", 8'h11, 32'hFFE);
    rd("R7", 8'h12);
    rd("R7", 8'h12);
    rd("R7", 8'h11);

    // R3 run word; R8 data port closed
    wr("R3", 8'h10, 32'h10B);
    wr("R4", 8'h11, 32'h0);
    wr("R8", 8'h12, 32'h77);
    rd("R8", 8'h12);
    rd("R8", 8'h11);
    wr("R3", 8'h10, 32'h08C);
    rd("R8", 8'h12);

    // R9 unmapped and hold
    rd("R9", 8'h13);
    wr("R9", 8'h0F, 32'hFFFF_FFFF);
    rd("R9", 8'h10);
    idle("R9"); idle("R9");

    // R10 both strobes
    wr("R4", 8'h11, 32'h5);
    rd("R10", 8'h11);
    cyc("R10", 1'b1, 1'b1, 8'h12, 32'h5A);
    rd("R10", 8'h11);
    wr("R4", 8'h11, 32'h5);
    rd("R10", 8'h12);

    summary();
    $finish;
  end
endmodule